// File: doc/BRIEF.md
# SD Card SPI-Mode Command Sender

This block issues a single SD-card command over a byte-wide SPI master and returns the first response byte. The caller presents a 6-bit command index and a 32-bit argument and pulses `startReq`. The engine latches both and raises `busy`. It then runs each byte of the frame through the SPI master, one exchange at a time: first a filler byte that gives the card spare clocks, then the command byte, the argument and a checksum byte.

After the frame, the engine keeps clocking out `0xFF` and inspects each byte it receives. The first byte whose top bit is clear is the card's one-byte status. If no such byte arrives within a bounded number of polls, the engine gives up and reports a timeout. Chip select, the bit-level shifter and any trailing response bytes stay with the caller. The caller reads those trailing bytes directly through the SPI master once `done` has pulsed.

Top module: `sdCmdEngine`

## Requirements
- R1: Each transaction starts with `IDLE_BYTES` (default 1) filler bytes of value 0xFF. The frame is then command byte, argument bytes, checksum byte, so a default frame is 7 bytes.
- R2: The command byte is 0x40 OR'd with the latched 6-bit command index. Bit 7 of this byte is 0 and bit 6 is 1.
- R3: The argument follows the command byte as four bytes, most significant byte first.
- R4: The checksum byte is 0x95 when the index is 0, 0x87 when the index is 8, and 0xFF for every other index.
- R5: After the frame, every byte sent while polling is 0xFF. Only one SPI exchange is outstanding at a time: `spiStart` is a one-cycle request, and no new request is made until `spiDone` has answered the previous one.
- R6: Polling stops at the first received poll byte whose bit 7 is 0. That byte is returned unchanged on `respByte` with `timedOut` low. Its status bits are passed through as received: bit 0 idle, bit 1 erase reset, bit 2 illegal command, bit 3 CRC error, bit 4 erase sequence error, bit 5 address error, bit 6 parameter error.
- R7: If `POLL_LIMIT` (default 10) polls all read back a byte with bit 7 set, the engine stops after exactly that many polls. It then reports `timedOut` high and `respByte` = 0xFF.
- R8: A `startReq` that arrives while `busy` is high is ignored. The running frame keeps the index and argument that were latched when it started, and no second transaction follows.
- R9: `busy` rises in the cycle after an accepted start. `done` is high for exactly one cycle, and `busy` is still high during that cycle. `respByte` and `timedOut` keep their values until the next accepted start.
- R10: After reset, `busy`, `done`, `spiStart` and `timedOut` are low and `respByte` is 0xFF.
- R11: Bytes received while the frame itself is being sent are discarded, even if their bit 7 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Request to send one command; taken only when idle |
| cmdIndex | input | 6 | Command index |
| cmdArg | input | 32 | Command argument |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| respByte | output | 8 | Status byte, or 0xFF on timeout |
| timedOut | output | 1 | No response within the poll limit |
| spiStart | output | 1 | One-cycle request for an SPI byte exchange |
| spiTxByte | output | 8 | Byte to send, valid with spiStart |
| spiDone | input | 1 | Exchange finished; spiRxByte valid |
| spiRxByte | input | 8 | Byte received in the exchange |

## Verification
The bench sweeps all 64 command indices, each with a distinct argument pattern. This separates the checksum special cases (indices 0 and 8) from the general case and confirms byte order across the argument. For each index it moves the position of the first clear-top-bit poll byte through every poll slot and then past the limit, so a hit on the first poll, on the last poll and a timeout are all told apart. During the frame the modelled card returns bytes with bit 7 clear, which exposes any engine that polls too early. SPI latency varies from exchange to exchange, and some runs carry a stray start with a different index in mid-flight; these show whether the engine waits on `spiDone` and whether its latched inputs hold.

// File: rtl/sdCmdPkg.sv
package sdCmdPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_FINISH
  } ctlState_t;

  typedef struct packed {
    logic load;
    logic advance;
    logic capture;
    logic expire;
  } ctlStrobe_t;

  localparam logic [7:0] FILL_BYTE    = 8'hFF;
  localparam logic [1:0] CMD_PREFIX   = 2'b01;
  localparam logic [7:0] CRC_RESET    = 8'h95;
  localparam logic [7:0] CRC_IFCOND   = 8'h87;
  localparam logic [5:0] IDX_RESET    = 6'd0;
  localparam logic [5:0] IDX_IFCOND   = 6'd8;

endpackage

// File: rtl/sdCmdDatapath.sv
module sdCmdDatapath
  import sdCmdPkg::*;
#(
  parameter int IDLE_BYTES = 1,
  parameter int POLL_LIMIT = 10,
  parameter int ARG_BYTES  = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctlStrobe_t             stb,
  input  logic [5:0]             cmdIndex,
  input  logic [8*ARG_BYTES-1:0] cmdArg,
  input  logic [7:0]             spiRxByte,
  output logic [7:0]             txByte,
  output logic                   inPoll,
  output logic                   pollLast,
  output logic                   respOk,
  output logic [7:0]             respByte,
  output logic                   timedOut
);

  localparam int FRAME_LEN = IDLE_BYTES + 2 + ARG_BYTES;
  localparam int SEQ_W     = $clog2(FRAME_LEN);
  localparam int POLL_W    = $clog2(POLL_LIMIT + 1);
  localparam int ARG_W     = 8 * ARG_BYTES;

  logic [5:0]       cmdReg;
  logic [ARG_W-1:0] argReg;
  logic [SEQ_W-1:0] seqIdx;
  logic [POLL_W-1:0] pollCnt;
  logic             pollPhase;
  logic [7:0]       respReg;
  logic             toReg;
  logic [7:0]       argBytes [ARG_BYTES];
  logic [7:0]       crcByte;

  // Split the argument into bytes, index 0 being the most significant.
  for (genvar j = 0; j < ARG_BYTES; j++) begin : gArgSplit
    assign argBytes[j] = argReg[8*(ARG_BYTES-1-j) +: 8];
  end

  always_comb begin
    if (cmdReg == IDX_RESET)       crcByte = CRC_RESET;
    else if (cmdReg == IDX_IFCOND) crcByte = CRC_IFCOND;
    else                           crcByte = FILL_BYTE;
  end

  always_comb begin
    txByte = FILL_BYTE;
    if (!pollPhase) begin
      if (seqIdx == SEQ_W'(IDLE_BYTES)) begin
        txByte = {CMD_PREFIX, cmdReg};
      end else if (seqIdx == SEQ_W'(FRAME_LEN - 1)) begin
        txByte = crcByte;
      end else begin
        for (int j = 0; j < ARG_BYTES; j++) begin
          if (seqIdx == SEQ_W'(IDLE_BYTES + 1 + j)) txByte = argBytes[j];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg    <= '0;
      argReg    <= '0;
      seqIdx    <= '0;
      pollCnt   <= '0;
      pollPhase <= 1'b0;
      respReg   <= FILL_BYTE;
      toReg     <= 1'b0;
    end else begin
      if (stb.load) begin
        cmdReg    <= cmdIndex;
        argReg    <= cmdArg;
        seqIdx    <= '0;
        pollCnt   <= '0;
        pollPhase <= 1'b0;
        respReg   <= FILL_BYTE;
        toReg     <= 1'b0;
      end
      if (stb.advance) begin
        if (!pollPhase) begin
          if (seqIdx == SEQ_W'(FRAME_LEN - 1)) pollPhase <= 1'b1;
          else                                 seqIdx <= seqIdx + 1'b1;
        end else begin
          pollCnt <= pollCnt + 1'b1;
        end
      end
      if (stb.capture) begin
        respReg <= spiRxByte;
        toReg   <= 1'b0;
      end
      if (stb.expire) begin
        respReg <= FILL_BYTE;
        toReg   <= 1'b1;
      end
    end
  end

  assign inPoll   = pollPhase;
  assign pollLast = pollPhase && (pollCnt == POLL_W'(POLL_LIMIT - 1));
  assign respOk   = !spiRxByte[7];
  assign respByte = respReg;
  assign timedOut = toReg;

endmodule

// File: rtl/sdCmdControl.sv
module sdCmdControl
  import sdCmdPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       spiDone,
  input  logic       inPoll,
  input  logic       pollLast,
  input  logic       respOk,
  output ctlStrobe_t stb,
  output logic       spiStart,
  output logic       busy,
  output logic       done
);

  ctlState_t state, stateNext;

  always_comb begin
    stateNext = state;
    stb       = '0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          stb.load  = 1'b1;
          stateNext = ST_ISSUE;
        end
      end
      ST_ISSUE: stateNext = ST_WAIT;
      ST_WAIT: begin
        if (spiDone) begin
          if (inPoll && respOk) begin
            stb.capture = 1'b1;
            stateNext   = ST_FINISH;
          end else if (pollLast) begin
            stb.expire = 1'b1;
            stateNext  = ST_FINISH;
          end else begin
            stb.advance = 1'b1;
            stateNext   = ST_ISSUE;
          end
        end
      end
      ST_FINISH: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign spiStart = (state == ST_ISSUE);
  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_FINISH);

endmodule

// File: rtl/sdCmdEngine.sv
module sdCmdEngine
  import sdCmdPkg::*;
#(
  parameter int IDLE_BYTES = 1,
  parameter int POLL_LIMIT = 10,
  parameter int ARG_BYTES  = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   startReq,
  input  logic [5:0]             cmdIndex,
  input  logic [8*ARG_BYTES-1:0] cmdArg,
  output logic                   busy,
  output logic                   done,
  output logic [7:0]             respByte,
  output logic                   timedOut,
  output logic                   spiStart,
  output logic [7:0]             spiTxByte,
  input  logic                   spiDone,
  input  logic [7:0]             spiRxByte
);

  ctlStrobe_t stb;
  logic       inPoll;
  logic       pollLast;
  logic       respOk;

  sdCmdControl uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .spiDone  (spiDone),
    .inPoll   (inPoll),
    .pollLast (pollLast),
    .respOk   (respOk),
    .stb      (stb),
    .spiStart (spiStart),
    .busy     (busy),
    .done     (done)
  );

  sdCmdDatapath #(
    .IDLE_BYTES (IDLE_BYTES),
    .POLL_LIMIT (POLL_LIMIT),
    .ARG_BYTES  (ARG_BYTES)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cmdIndex  (cmdIndex),
    .cmdArg    (cmdArg),
    .spiRxByte (spiRxByte),
    .txByte    (spiTxByte),
    .inPoll    (inPoll),
    .pollLast  (pollLast),
    .respOk    (respOk),
    .respByte  (respByte),
    .timedOut  (timedOut)
  );

endmodule

// File: rtl/sdCmdChk.sv
module sdCmdChk #(
  parameter int IDLE_BYTES = 1,
  parameter int POLL_LIMIT = 10,
  parameter int ARG_BYTES  = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic       startReq,
  input logic       busy,
  input logic       done,
  input logic [7:0] respByte,
  input logic       timedOut,
  input logic       spiStart,
  input logic       spiDone
);

  localparam int FRAME_LEN = IDLE_BYTES + 2 + ARG_BYTES;
  localparam int TOTAL     = FRAME_LEN + POLL_LIMIT;

  logic        outstanding;
  logic [15:0] issueCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outstanding <= 1'b0;
      issueCnt    <= '0;
    end else begin
      if (spiStart)     outstanding <= 1'b1;
      else if (spiDone) outstanding <= 1'b0;
      issueCnt <= busy ? issueCnt + 16'(spiStart) : 16'd0;
    end
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    spiStart |-> !outstanding); // R5
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !spiStart && !done); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy); // R9
  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy); // R9
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !startReq) |=> $stable(respByte) && $stable(timedOut)); // R9
  AST_STAY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy); // R8
  AST_TIMEOUT_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    (done && timedOut) |-> respByte == 8'hFF); // R7
  AST_TIMEOUT_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (done && timedOut) |-> issueCnt == 16'(TOTAL)); // R7
  AST_RESP_TOPCLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (done && !timedOut) |-> !respByte[7]); // R6
  AST_RESP_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    (done && !timedOut) |-> issueCnt > 16'(FRAME_LEN) && issueCnt <= 16'(TOTAL)); // R11

endmodule

bind sdCmdEngine sdCmdChk #(
  .IDLE_BYTES (IDLE_BYTES),
  .POLL_LIMIT (POLL_LIMIT),
  .ARG_BYTES  (ARG_BYTES)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .startReq (startReq),
  .busy     (busy),
  .done     (done),
  .respByte (respByte),
  .timedOut (timedOut),
  .spiStart (spiStart),
  .spiDone  (spiDone)
);

// File: tb/tb_sdCmdEngine.sv
`timescale 1ns/1ps
module tb_sdCmdEngine;

  localparam int FRAME_LEN = 7;
  localparam int POLLS     = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [5:0]  cmdIndex = '0;
  logic [31:0] cmdArg = '0;
  logic        busy, done, timedOut, spiStart;
  logic [7:0]  respByte, spiTxByte;
  logic        spiDone = 1'b0;
  logic [7:0]  spiRxByte = 8'h00;

  int total = 0;
  int bad = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  sdCmdEngine dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cmdIndex(cmdIndex),
    .cmdArg(cmdArg), .busy(busy), .done(done), .respByte(respByte),
    .timedOut(timedOut), .spiStart(spiStart), .spiTxByte(spiTxByte),
    .spiDone(spiDone), .spiRxByte(spiRxByte)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expTx(input logic [5:0] idx, input logic [31:0] arg, input int n);
    if (n == 0) return 8'hFF;                    // R1 filler
    if (n == 1) return 8'h40 + {2'b00, idx};     // R2
    if (n >= 2 && n <= 5) return 8'((arg >> (8 * (5 - n))) & 32'hFF); // R3
    if (n == 6) return (idx == 6'd0) ? 8'h95 : (idx == 6'd8) ? 8'h87 : 8'hFF; // R4
    return 8'hFF;                                // R5 polls
  endfunction

  task automatic runCmd(input logic [5:0] idx, input logic [31:0] arg, input int respPos,
                        input logic [7:0] respVal, input int latBase, input bit inject);
    int n = 0;
    bit finished = 0;
    int expCount;
    @(negedge clk);
    cmdIndex = idx; cmdArg = arg; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(busy === 1'b1, "R9 busy after start", int'(busy), 1);
    while (!finished && n < 40) begin
      if (done) begin
        finished = 1;
      end else if (spiStart) begin
        int lat = 1 + (latBase + n) % 3;
        if (n < FRAME_LEN) check(spiTxByte === expTx(idx, arg, n),
          (n == 0) ? "R1 filler" : (n == 1) ? "R2 cmd byte" : (n == 6) ? "R4 crc" : "R3 arg byte",
          int'(spiTxByte), int'(expTx(idx, arg, n)));
        else check(spiTxByte === 8'hFF, "R5 poll byte", int'(spiTxByte), 8'hFF);
        @(negedge clk);
        check(spiStart === 1'b0, "R5 single request", int'(spiStart), 0);
        if (inject && n == 3) begin
          startReq = 1'b1; cmdIndex = ~idx; cmdArg = ~arg;   // R8 stray start
        end
        repeat (lat - 1) @(negedge clk);
        startReq = 1'b0;
        spiDone = 1'b1;
        if (n < FRAME_LEN) spiRxByte = 8'h01;                 // R11 bait
        else if (n - FRAME_LEN == respPos) spiRxByte = respVal;
        else spiRxByte = 8'h80 | 8'(n);
        n++;
        @(negedge clk);
        spiDone = 1'b0;
        spiRxByte = 8'h00;
      end else begin
        @(negedge clk);
      end
    end
    expCount = (respPos < POLLS) ? FRAME_LEN + respPos + 1 : FRAME_LEN + POLLS;
    check(finished, "R9 done seen", int'(finished), 1);
    check(n == expCount, (respPos < POLLS) ? "R6 exchange count" : "R7 exchange count", n, expCount);
    check(busy === 1'b1, "R9 busy during done", int'(busy), 1);
    if (respPos < POLLS) begin
      check(respByte === respVal, "R6 response value", int'(respByte), int'(respVal));
      check(timedOut === 1'b0, "R6 no timeout", int'(timedOut), 0);
    end else begin
      check(respByte === 8'hFF, "R7 timeout value", int'(respByte), 8'hFF);
      check(timedOut === 1'b1, "R7 timeout flag", int'(timedOut), 1);
    end
    @(negedge clk);
    check(done === 1'b0, "R9 done one cycle", int'(done), 0);
    repeat (3) begin
      check(busy === 1'b0 && spiStart === 1'b0, "R8 no second transaction",
            int'({busy, spiStart}), 0);
      @(negedge clk);
    end
    check(respByte === ((respPos < POLLS) ? respVal : 8'hFF), "R9 result held",
          int'(respByte), int'((respPos < POLLS) ? respVal : 8'hFF));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && spiStart === 1'b0 && timedOut === 1'b0,
          "R10 reset outputs", int'({busy, done, spiStart, timedOut}), 0);
    check(respByte === 8'hFF, "R10 reset response", int'(respByte), 8'hFF);
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      logic [31:0] a = {8'(i * 37 + 1), 8'(i ^ 8'h5A), 8'(255 - i), 8'(i * 3)};
      logic [7:0]  rv = 8'((i * 29) & 8'h7F);
      runCmd(6'(i), a, i % 12, rv, i, (i % 5) == 2);
    end
    runCmd(6'd0, 32'h0, 0, 8'h01, 0, 0);
    runCmd(6'd8, 32'h0000_01AA, 9, 8'h04, 1, 1);
    runCmd(6'd17, 32'hDEAD_BEEF, 10, 8'h00, 2, 0);
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule